// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit buffer descriptors kept in a small internal descriptor RAM. Each descriptor holds a 16-bit status word, a 16-bit byte count and a 32-bit buffer address. Software fills descriptors through a plain RAM port and hands each one to the engine by setting its ready bit. It then issues a one-cycle command that clears the halt condition. The engine fetches the descriptor at its current ring index. If that descriptor is ready, the engine presents a transfer request on a valid/ready handshake. When the downstream datapath reports completion, the engine writes the descriptor back with ready cleared and the completion error code recorded, and then moves on to the next index.

The end of the ring is marked by a wrap bit in a descriptor. The engine also wraps after the last RAM entry. When the engine meets a descriptor that is not ready, it halts and raises a halt event, and it stays idle until the next clear-halt command. A level-sensitive graceful stop request lets the frame in flight finish. The engine then parks and raises a stop-complete event. Dropping the request resumes the engine at the following ring index. Both event bits are sticky and are cleared by writing one.

Top module: `txdesc_ring`

## Requirements
- R1: After reset the engine is halted (`halted`=1), `req_valid` is 0 and both event bits are 0.
- R2: While halted, the engine issues no request, even when ready descriptors are present, until `clr_halt` is pulsed. After the pulse it fetches the descriptor at its current index.
- R3: Descriptor words on the software port are laid out as {status[63:48], length[47:32], pointer[31:0]}. Status bit 15 is READY, bit 12 is INTERRUPT, bit 11 is LAST and bit 10 is CRC-append. A request is raised only for a descriptor with READY set. The request carries its pointer, length and the three flags on `req_irq`, `req_last` and `req_crc`. All of these are held stable while `req_valid` is high and `req_ready` is low.
- R4: On `tx_done` the descriptor is written back with READY cleared, status bits 3:0 set to `tx_err`, and all other status bits, the length and the pointer unchanged.
- R5: After a descriptor with status bit 13 (WRAP) set, or after RAM entry DEPTH-1, the next descriptor is entry 0. Otherwise it is the next higher entry.
- R6: When the fetched descriptor lacks READY, the engine enters the halted state, sets event bit 0 and keeps its index, so that the same entry is fetched after the next `clr_halt`.
- R7: While `stop_req` is high, a frame already requested still completes. After that completion no new request is made, the engine does not report halted, and event bit 1 is set.
- R8: When `stop_req` falls, the engine resumes with the descriptor following the last completed one.
- R9: Each event bit is cleared by a 1 on the matching bit of `evt_clr`. If the engine sets a bit in the same cycle that it is cleared, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software descriptor write enable |
| sw_addr | input | $clog2(DEPTH) | Software descriptor index |
| sw_wdata | input | 64 | Descriptor word to write |
| sw_rdata | output | 64 | Descriptor word read at `sw_addr`, one cycle later |
| clr_halt | input | 1 | One-cycle command that leaves the halted state |
| stop_req | input | 1 | Graceful stop request (level) |
| evt_clr | input | 2 | Write-one-to-clear mask for the events |
| evt | output | 2 | Sticky events: bit 0 halt, bit 1 stop complete |
| halted | output | 1 | Engine is in the halted state |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Transfer request accepted |
| req_ptr | output | 32 | Buffer address of the request |
| req_len | output | 16 | Byte count of the request |
| req_crc | output | 1 | Append frame check sequence |
| req_last | output | 1 | Last buffer of the frame |
| req_irq | output | 1 | Interrupt on completion requested |
| tx_done | input | 1 | Completion pulse for the accepted request |
| tx_err | input | 4 | Error code that comes with `tx_done` |

## Verification
Two functions can fall in the same cycle. The engine can set the halt event at the same edge where software writes one to clear it. The bench provokes this by counting edges from its own `tx_done` pulse. The completion write-back lands at that edge, the re-fetch follows one edge later, and the not-ready check falls on the second edge after the pulse. The bench drives `evt_clr` for exactly that second edge and expects the event to read as set afterwards. A separate clear then proves that the bit does clear. The bench also sweeps every wrap position of a four-entry ring, including the implicit wrap at the last entry. In each sweep it checks the order of the requests and reads back every written descriptor.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_W  = 64;
  localparam int ERR_W   = 4;
  localparam int EVT_W   = 2;
  localparam int B_READY = 15;
  localparam int B_WRAP  = 13;
  localparam int B_IRQ   = 12;
  localparam int B_LAST  = 11;
  localparam int B_CRC   = 10;
  localparam int EV_HALT = 0;
  localparam int EV_STOP = 1;

  typedef struct packed {
    logic [15:0] status;
    logic [15:0] len;
    logic [31:0] ptr;
  } desc_t;

  typedef enum logic [2:0] {
    S_HALT, S_FETCH, S_CHECK, S_REQ, S_WAIT, S_STOP
  } eng_st_e;
endpackage

// File: rtl/txring_ram.sv
module txring_ram
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  desc_t         a_wdata,
  output desc_t         a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  desc_t         b_wdata,
  output desc_t         b_rdata
);
  desc_t mem [DEPTH];

  // Engine write follows software write, so the engine wins on a collision.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/txring_events.sv
module txring_events
  import txr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] set,
  input  logic [EVT_W-1:0] clr,
  output logic [EVT_W-1:0] evt
);
  always_ff @(posedge clk) begin
    if (rst) evt <= '0;
    else     evt <= (evt & ~clr) | set;
  end
endmodule

// File: rtl/txring_fsm.sv
module txring_fsm
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_halt,
  input  logic             stop_req,
  input  logic             req_ready,
  input  logic             tx_done,
  input  logic [ERR_W-1:0] tx_err,
  input  desc_t            rd_desc,
  output logic [AW-1:0]    ring_addr,
  output logic             wb_we,
  output desc_t            wb_desc,
  output logic [EVT_W-1:0] evt_set,
  output logic             halted,
  output logic             req_valid,
  output logic [31:0]      req_ptr,
  output logic [15:0]      req_len,
  output logic             req_crc,
  output logic             req_last,
  output logic             req_irq
);
  eng_st_e       state;
  logic [AW-1:0] idx;
  desc_t         cur;
  logic [AW-1:0] idx_next;
  logic [15:0]   st_done;

  always_comb begin
    idx_next = (cur.status[B_WRAP] || idx == AW'(DEPTH - 1)) ? '0 : idx + 1'b1;
    st_done  = cur.status;
    st_done[B_READY]   = 1'b0;
    st_done[ERR_W-1:0] = tx_err;
    wb_desc  = '{status: st_done, len: cur.len, ptr: cur.ptr};
    wb_we    = (state == S_WAIT) && tx_done;
    evt_set  = '0;
    evt_set[EV_HALT] = (state == S_CHECK) && !rd_desc.status[B_READY];
    evt_set[EV_STOP] = stop_req &&
                       ((state == S_FETCH) || ((state == S_WAIT) && tx_done));
  end

  assign ring_addr = idx;
  assign halted    = (state == S_HALT);
  assign req_valid = (state == S_REQ);
  assign req_ptr   = cur.ptr;
  assign req_len   = cur.len;
  assign req_crc   = cur.status[B_CRC];
  assign req_last  = cur.status[B_LAST];
  assign req_irq   = cur.status[B_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_HALT;
      idx   <= '0;
      cur   <= '0;
    end else begin
      unique case (state)
        S_HALT:  if (clr_halt) state <= S_FETCH;
        S_FETCH: state <= stop_req ? S_STOP : S_CHECK;
        S_CHECK: begin
          if (!rd_desc.status[B_READY]) begin
            state <= S_HALT;
          end else begin
            cur   <= rd_desc;
            state <= S_REQ;
          end
        end
        S_REQ:   if (req_ready) state <= S_WAIT;
        S_WAIT: begin
          if (tx_done) begin
            idx   <= idx_next;
            state <= stop_req ? S_STOP : S_FETCH;
          end
        end
        S_STOP:  if (!stop_req) state <= S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_ring.sv
module txdesc_ring
  import txr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_we,
  input  logic [AW-1:0]    sw_addr,
  input  logic [63:0]      sw_wdata,
  output logic [63:0]      sw_rdata,
  input  logic             clr_halt,
  input  logic             stop_req,
  input  logic [1:0]       evt_clr,
  output logic [1:0]       evt,
  output logic             halted,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [31:0]      req_ptr,
  output logic [15:0]      req_len,
  output logic             req_crc,
  output logic             req_last,
  output logic             req_irq,
  input  logic             tx_done,
  input  logic [3:0]       tx_err
);
  desc_t            a_rd, b_rd, wb_desc;
  logic [AW-1:0]    ring_addr;
  logic             wb_we;
  logic [EVT_W-1:0] evt_set;

  assign sw_rdata = a_rd;

  txring_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .a_we(sw_we), .a_addr(sw_addr), .a_wdata(desc_t'(sw_wdata)),
    .a_rdata(a_rd), .b_we(wb_we), .b_addr(ring_addr), .b_wdata(wb_desc),
    .b_rdata(b_rd)
  );

  txring_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst(rst), .clr_halt(clr_halt), .stop_req(stop_req),
    .req_ready(req_ready), .tx_done(tx_done), .tx_err(tx_err),
    .rd_desc(b_rd), .ring_addr(ring_addr), .wb_we(wb_we), .wb_desc(wb_desc),
    .evt_set(evt_set), .halted(halted), .req_valid(req_valid),
    .req_ptr(req_ptr), .req_len(req_len), .req_crc(req_crc),
    .req_last(req_last), .req_irq(req_irq)
  );

  txring_events u_evt (
    .clk(clk), .rst(rst), .set(evt_set), .clr(evt_clr), .evt(evt)
  );
endmodule

// File: rtl/txring_chk.sv
module txring_chk (
  input logic        clk,
  input logic        rst,
  input logic        halted,
  input logic        clr_halt,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_ptr,
  input logic [15:0] req_len,
  input logic        tx_done,
  input logic [1:0]  evt
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_ptr) && $stable(req_len));
  // R2
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    halted && !clr_halt |=> halted && !req_valid);
  // R6
  halt_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> evt[0]);
  // R7
  stop_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt[1]) |-> !req_valid);
  // R4
  done_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done && !req_valid |=> !req_valid);
endmodule

bind txdesc_ring txring_chk u_chk (
  .clk(clk), .rst(rst), .halted(halted), .clr_halt(clr_halt),
  .req_valid(req_valid), .req_ready(req_ready), .req_ptr(req_ptr),
  .req_len(req_len), .tx_done(tx_done), .evt(evt)
);

// File: tb/txdesc_ring_tb.sv
module txdesc_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1;
  logic sw_we = 1'b0;
  logic [AW-1:0] sw_addr = '0;
  logic [63:0] sw_wdata = '0, sw_rdata;
  logic clr_halt = 1'b0, stop_req = 1'b0;
  logic [1:0] evt_clr = '0, evt;
  logic halted, req_valid, req_ready = 1'b0;
  logic [31:0] req_ptr;
  logic [15:0] req_len;
  logic req_crc, req_last, req_irq;
  logic tx_done = 1'b0;
  logic [3:0] tx_err = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;
  logic [63:0] shadow [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_ring #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .clr_halt(clr_halt), .stop_req(stop_req),
    .evt_clr(evt_clr), .evt(evt), .halted(halted), .req_valid(req_valid),
    .req_ready(req_ready), .req_ptr(req_ptr), .req_len(req_len),
    .req_crc(req_crc), .req_last(req_last), .req_irq(req_irq),
    .tx_done(tx_done), .tx_err(tx_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_desc(input int i, input logic [15:0] st, input logic [15:0] len,
                         input logic [31:0] ptr);
    sw_we = 1'b1; sw_addr = AW'(i); sw_wdata = {st, len, ptr};
    shadow[i] = {st, len, ptr};
    nclk(1);
    sw_we = 1'b0;
  endtask

  task automatic rd_desc(input int i, output logic [63:0] d);
    sw_addr = AW'(i);
    nclk(1);
    d = sw_rdata;
  endtask

  task automatic pulse_clr_halt();
    clr_halt = 1'b1; nclk(1); clr_halt = 1'b0;
  endtask

  task automatic clr_events(input logic [1:0] m);
    evt_clr = m; nclk(1); evt_clr = '0;
  endtask

  // Accept the request for descriptor i, compare it with shadow[i], complete it with err.
  task automatic serve(input int i, input logic [3:0] err, input string req);
    int w;
    logic [15:0] st;
    st = shadow[i][63:48];
    w = 0;
    while (!req_valid && w < 60) begin nclk(1); w++; end
    chk({req, " request present"}, 64'(req_valid), 64'd1);
    chk({req, " ptr"}, 64'(req_ptr), 64'(shadow[i][31:0]));
    chk({req, " len"}, 64'(req_len), 64'(shadow[i][47:32]));
    chk({req, " flags"}, 64'({req_irq, req_last, req_crc}), 64'({st[12], st[11], st[10]}));
    nclk(2);
    chk("R3 held while stalled", {req_valid, 15'd0, req_len, req_ptr},
        {1'b1, 15'd0, shadow[i][47:32], shadow[i][31:0]});
    req_ready = 1'b1; nclk(1); req_ready = 1'b0;
    tx_done = 1'b1; tx_err = err; nclk(1); tx_done = 1'b0; tx_err = '0;
    shadow[i][63] = 1'b0;
    shadow[i][51:48] = err;
  endtask

  task automatic wait_halt(input string req);
    int w;
    w = 0;
    while (!halted && w < 30) begin nclk(1); w++; end
    chk({req, " halted"}, 64'(halted), 64'd1);
    chk({req, " halt event"}, 64'(evt[0]), 64'd1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    nclk(3);
    rst = 1'b0;
    nclk(1);
    // R1
    chk("R1 halted after reset", 64'(halted), 64'd1);
    chk("R1 no request after reset", 64'(req_valid), 64'd0);
    chk("R1 events clear after reset", 64'(evt), 64'd0);

    // Sweep every wrap position; t = 3 relies on the wrap after entry DEPTH-1 (R5).
    for (int t = 0; t < DEPTH; t++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [15:0] st;
        st = '0;
        if (i <= t) begin
          st[15] = 1'b1;
          st[13] = (i == t) && (t < DEPTH - 1);
          st[12] = i[1];
          st[11] = (i == t);
          st[10] = i[0] ^ t[0];
        end
        wr_desc(i, st, 16'(64 + t * 8 + i), 32'h1000_0000 + 32'(t * 256 + i * 16));
      end
      nclk(5);
      // R2
      chk("R2 no request while halted", 64'(req_valid), 64'd0);
      pulse_clr_halt();
      for (int i = 0; i <= t; i++) serve(i, 4'((t * 3 + i + 1) % 16), "R5 ring order R3");
      // R6
      wait_halt("R6 not-ready entry");
      for (int i = 0; i < DEPTH; i++) begin
        rd_desc(i, d);
        chk("R4 write-back", d, shadow[i]);
      end
      clr_events(2'b01);
      nclk(1);
      // R9
      chk("R9 write-one clear", 64'(evt), 64'd0);
    end

    // Graceful stop: R7 and R8.
    wr_desc(0, 16'h8C00, 16'd100, 32'hA000_0000);
    wr_desc(1, 16'h8800, 16'd101, 32'hA000_0100);
    wr_desc(2, 16'hA800, 16'd102, 32'hA000_0200);
    wr_desc(3, 16'h0000, 16'd0, 32'h0);
    pulse_clr_halt();
    while (!req_valid) nclk(1);
    stop_req = 1'b1;
    serve(0, 4'h0, "R7 frame in flight");
    nclk(10);
    chk("R7 no request while stopped", 64'(req_valid), 64'd0);
    chk("R7 stop event", 64'(evt), 64'b10);
    chk("R7 not halted while stopped", 64'(halted), 64'd0);
    rd_desc(0, d);
    chk("R7 in-flight descriptor completed", d, shadow[0]);
    rd_desc(1, d);
    chk("R7 next descriptor untouched", d, shadow[1]);
    clr_events(2'b10);
    stop_req = 1'b0;
    serve(1, 4'h7, "R8 resume index");
    serve(2, 4'h2, "R8 continue");
    wait_halt("R6 after resume");
    clr_events(2'b11);

    // Same-cycle set and clear of the halt event.
    wr_desc(0, 16'hA800, 16'd77, 32'hB000_0000);
    pulse_clr_halt();
    while (!req_valid) nclk(1);
    req_ready = 1'b1; nclk(1); req_ready = 1'b0;
    tx_done = 1'b1; nclk(1); tx_done = 1'b0;
    nclk(1);
    evt_clr = 2'b01; nclk(1); evt_clr = '0;
    chk("R9 set wins over clear", 64'(evt[0]), 64'd1);
    chk("R6 halted again", 64'(halted), 64'd1);
    clr_events(2'b01);
    chk("R9 clear after collision", 64'(evt[0]), 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule